// File: doc/BRIEF.md
# Communication Cycle Slot Scheduler

This block paces a time-triggered bus schedule. Each communication cycle passes through four phases in fixed order: a static phase made of equal-length slots, a dynamic phase built from minislots, a symbol window and a closing idle gap in which no frame may start. All timing advances only on a macrotick enable, so the block runs from any system clock. It keeps a slot number that starts at 1 in the static phase and keeps counting through the dynamic phase. It also keeps a 6-bit cycle count.

A table of transmit entries gives each entry a frame ID and a length in minislots. An entry is granted when its ID equals the current slot number and its request bit is set. In the static phase this is plain time-division access. In the dynamic phase, slot numbers act as priorities. A dynamic slot with no grant uses one minislot. A granted dynamic slot stretches to the entry's configured length, but only if that many minislots are still left in the phase. The grant is a one-macrotick pulse in the first macrotick of a slot. The host uses it to launch the frame. Grant, request and configuration are plain control pins with no handshake. Configuration is assumed stable while the block runs, and every length and count is assumed to be at least 1.

Top module: `cycle_sched`

## Requirements
- R1: After reset, seg reads 0 (static), slot reads 1, cycle reads 0 and grant is all zero.
- R2: seg follows the order 0 static, 1 dynamic, 2 symbol, 3 idle gap, then back to 0. It never skips a phase.
- R3: Each static slot lasts cfg_st_len macroticks. Static slots are numbered 1 to cfg_st_slots.
- R4: In the first macrotick of a static slot, grant bit i is high when tx_id entry i equals slot and req[i] is set. When several entries qualify, only the lowest index is granted, so grant has at most one bit set.
- R5: Dynamic slot numbers continue from cfg_st_slots+1. A dynamic slot with no grant lasts one minislot of cfg_ms_len macroticks.
- R6: A granted dynamic slot lasts tx_ms[i] minislots, where tx_ms[i] is the granted entry's configured length.
- R7: A dynamic grant is withheld when the minislots left in the phase are fewer than the entry's tx_ms. That slot then lasts one minislot.
- R8: The dynamic phase ends after exactly cfg_ms_count minislots. The symbol window then lasts cfg_sym_len macroticks and the idle gap lasts cfg_nit_len macroticks. In both of these, slot reads 0 and grant stays zero.
- R9: cycle rises by one on each return from the idle gap to the static phase, and wraps from 63 to 0.
- R10: While mt_en is low, seg, slot and cycle hold their values and grant stays zero.
- R11: A grant bit is never set without its request bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mt_en | input | 1 | Macrotick enable; one macrotick per high cycle |
| cfg_st_slots | input | SLOT_W | Number of static slots |
| cfg_st_len | input | LEN_W | Static slot length in macroticks |
| cfg_ms_count | input | MS_W | Minislots in the dynamic phase |
| cfg_ms_len | input | LEN_W | Minislot length in macroticks |
| cfg_sym_len | input | LEN_W | Symbol window length in macroticks |
| cfg_nit_len | input | LEN_W | Idle gap length in macroticks |
| tx_id | input | NUM_TX*SLOT_W | Frame ID per entry, entry 0 in the low bits |
| tx_ms | input | NUM_TX*MS_W | Dynamic length in minislots per entry |
| req | input | NUM_TX | Pending transmit request per entry |
| seg | output | 2 | Phase: 0 static, 1 dynamic, 2 symbol, 3 idle gap |
| slot | output | SLOT_W | Current slot number, 0 outside slots |
| cycle | output | 6 | Cycle count |
| grant | output | NUM_TX | One-hot transmit grant pulse |

## Verification
grant is combinational. It is valid in the same clock as the first macrotick of a slot, so the bench drives req on the falling edge and reads grant a moment later in that same cycle. seg, slot and cycle are registered and change one clock after the macrotick that ends a slot. The bench therefore measures each slot's length by counting falling edges until {seg, slot} changes. That count must equal the expected macrotick count, because mt_en is held high. Holds under a low mt_en and the wrap of the cycle count are checked at falling edges after whole cycles have elapsed.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic [1:0] {
    SEG_STATIC = 2'd0,
    SEG_DYN    = 2'd1,
    SEG_SYMBOL = 2'd2,
    SEG_NIT    = 2'd3
  } seg_e;
endpackage

// File: rtl/cs_wrap_cnt.sv
// Macrotick counter inside the current slot or phase; wraps at lim.
module cs_wrap_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         first,
  output logic         last
);
  logic [W-1:0] cnt_q;

  assign first = (cnt_q == '0);
  assign last  = (cnt_q == W'(lim - 1'b1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cnt_q <= '0;
    else if (en) cnt_q <= last ? '0 : W'(cnt_q + 1'b1);
  end
endmodule

// File: rtl/cs_match.sv
// Compares every table entry with the slot number; lowest index wins.
module cs_match #(
  parameter int NUM_TX = 4,
  parameter int SLOT_W = 11,
  parameter int MS_W   = 10
) (
  input  logic [SLOT_W-1:0]        slot,
  input  logic [NUM_TX-1:0]        req,
  input  logic [NUM_TX*SLOT_W-1:0] tx_id,
  input  logic [NUM_TX*MS_W-1:0]   tx_ms,
  output logic                     hit,
  output logic [NUM_TX-1:0]        hit_oh,
  output logic [MS_W-1:0]          hit_ms
);
  logic [NUM_TX-1:0] cand;

  for (genvar i = 0; i < NUM_TX; i++) begin : g_cmp
    assign cand[i] = req[i] && (tx_id[i*SLOT_W +: SLOT_W] == slot);
  end

  always_comb begin
    hit_oh = '0;
    hit_ms = '0;
    for (int i = NUM_TX - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit_oh = '0;
        hit_oh[i] = 1'b1;
        hit_ms = tx_ms[i*MS_W +: MS_W];
      end
    end
  end

  assign hit = |cand;
endmodule

// File: rtl/cycle_sched.sv
module cycle_sched
  import cs_pkg::*;
#(
  parameter int NUM_TX = 4,
  parameter int SLOT_W = 11,
  parameter int MS_W   = 10,
  parameter int LEN_W  = 8,
  parameter int CYC_W  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mt_en,
  input  logic [SLOT_W-1:0]        cfg_st_slots,
  input  logic [LEN_W-1:0]         cfg_st_len,
  input  logic [MS_W-1:0]          cfg_ms_count,
  input  logic [LEN_W-1:0]         cfg_ms_len,
  input  logic [LEN_W-1:0]         cfg_sym_len,
  input  logic [LEN_W-1:0]         cfg_nit_len,
  input  logic [NUM_TX*SLOT_W-1:0] tx_id,
  input  logic [NUM_TX*MS_W-1:0]   tx_ms,
  input  logic [NUM_TX-1:0]        req,
  output logic [1:0]               seg,
  output logic [SLOT_W-1:0]        slot,
  output logic [CYC_W-1:0]         cycle,
  output logic [NUM_TX-1:0]        grant
);
  localparam logic [MS_W-1:0]   ONE_MS   = MS_W'(1);
  localparam logic [SLOT_W-1:0] FIRST_SL = SLOT_W'(1);

  seg_e              seg_q;
  logic [SLOT_W-1:0] slot_q;
  logic [CYC_W-1:0]  cyc_q;
  logic [MS_W-1:0]   ms_used_q, ms_in_slot_q, slot_len_q;

  logic [LEN_W-1:0]  tick_lim;
  logic              tick_first, tick_last;
  logic              hit;
  logic [NUM_TX-1:0] hit_oh;
  logic [MS_W-1:0]   hit_ms, dyn_left, cur_len;
  logic              slot_start, fits, grant_ok, in_slot_phase;

  always_comb begin
    case (seg_q)
      SEG_STATIC: tick_lim = cfg_st_len;
      SEG_DYN:    tick_lim = cfg_ms_len;
      SEG_SYMBOL: tick_lim = cfg_sym_len;
      default:    tick_lim = cfg_nit_len;
    endcase
  end

  cs_wrap_cnt #(.W(LEN_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(mt_en), .lim(tick_lim),
    .first(tick_first), .last(tick_last)
  );

  cs_match #(.NUM_TX(NUM_TX), .SLOT_W(SLOT_W), .MS_W(MS_W)) u_match (
    .slot(slot_q), .req(req), .tx_id(tx_id), .tx_ms(tx_ms),
    .hit(hit), .hit_oh(hit_oh), .hit_ms(hit_ms)
  );

  assign in_slot_phase = (seg_q == SEG_STATIC) || (seg_q == SEG_DYN);
  assign slot_start    = tick_first && (ms_in_slot_q == '0) && in_slot_phase;
  assign dyn_left      = MS_W'(cfg_ms_count - ms_used_q);
  assign fits          = (hit_ms <= dyn_left);
  assign grant_ok      = mt_en && slot_start && hit &&
                         ((seg_q == SEG_STATIC) || fits);
  assign cur_len       = slot_start ? ((seg_q == SEG_DYN && grant_ok) ? hit_ms : ONE_MS)
                                    : slot_len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q        <= SEG_STATIC;
      slot_q       <= FIRST_SL;
      cyc_q        <= '0;
      ms_used_q    <= '0;
      ms_in_slot_q <= '0;
      slot_len_q   <= ONE_MS;
    end else if (mt_en) begin
      case (seg_q)
        SEG_STATIC: if (tick_last) begin
          slot_q <= SLOT_W'(slot_q + 1'b1);
          if (slot_q == cfg_st_slots) begin
            seg_q        <= SEG_DYN;
            ms_used_q    <= '0;
            ms_in_slot_q <= '0;
          end
        end
        SEG_DYN: begin
          slot_len_q <= cur_len;
          if (tick_last) begin
            ms_used_q <= MS_W'(ms_used_q + 1'b1);
            if (MS_W'(ms_in_slot_q + 1'b1) == cur_len) begin
              ms_in_slot_q <= '0;
              if (MS_W'(ms_used_q + 1'b1) == cfg_ms_count) begin
                seg_q  <= SEG_SYMBOL;
                slot_q <= '0;
              end else begin
                slot_q <= SLOT_W'(slot_q + 1'b1);
              end
            end else begin
              ms_in_slot_q <= MS_W'(ms_in_slot_q + 1'b1);
            end
          end
        end
        SEG_SYMBOL: if (tick_last) seg_q <= SEG_NIT;
        default: if (tick_last) begin
          seg_q  <= SEG_STATIC;
          slot_q <= FIRST_SL;
          cyc_q  <= CYC_W'(cyc_q + 1'b1);
        end
      endcase
    end
  end

  assign seg   = seg_q;
  assign slot  = slot_q;
  assign cycle = cyc_q;
  assign grant = grant_ok ? hit_oh : '0;
endmodule

// File: rtl/cycle_sched_chk.sv
module cycle_sched_chk #(
  parameter int NUM_TX = 4,
  parameter int SLOT_W = 11,
  parameter int CYC_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mt_en,
  input logic [SLOT_W-1:0] cfg_st_slots,
  input logic [NUM_TX-1:0] req,
  input logic [1:0]        seg,
  input logic [SLOT_W-1:0] slot,
  input logic [CYC_W-1:0]  cycle,
  input logic [NUM_TX-1:0] grant
);
  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_grant_needs_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~req) == '0);

  assert_no_grant_outside_slots_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> (seg == 2'd0 || seg == 2'd1));

  assert_seg_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(seg) |-> (seg == 2'($past(seg) + 2'd1)));

  assert_cycle_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(seg) == 2'd3 && seg == 2'd0) |-> (cycle == CYC_W'($past(cycle) + 1'b1)));

  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !mt_en |=> ($stable(seg) && $stable(slot) && $stable(cycle)));

  assert_static_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (seg == 2'd0) |-> (slot >= SLOT_W'(1) && slot <= cfg_st_slots));
endmodule

bind cycle_sched cycle_sched_chk #(.NUM_TX(NUM_TX), .SLOT_W(SLOT_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mt_en(mt_en), .cfg_st_slots(cfg_st_slots),
  .req(req), .seg(seg), .slot(slot), .cycle(cycle), .grant(grant)
);

// File: tb/sim_cycle_sched.sv
module sim_cycle_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NTX = 5;
  localparam int SW  = 11;
  localparam int MW  = 10;
  localparam int LW  = 8;
  localparam int NROWS = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mt_en = 1'b1;
  logic [NTX-1:0] req = '0;
  logic [1:0]    seg;
  logic [SW-1:0] slot;
  logic [5:0]    cycle;
  logic [NTX-1:0] grant;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // entries: e0 id2/2ms, e1 id4/3ms, e2 id5/3ms, e3 id2/1ms, e4 id7/2ms
  logic [NTX*SW-1:0] tx_id = {11'd7, 11'd2, 11'd5, 11'd4, 11'd2};
  logic [NTX*MW-1:0] tx_ms = {10'd2, 10'd1, 10'd3, 10'd3, 10'd2};

  always #(CLK_PERIOD/2) clk = ~clk;

  cycle_sched #(.NUM_TX(NTX), .SLOT_W(SW), .MS_W(MW), .LEN_W(LW), .CYC_W(6)) u0 (
    .clk(clk), .rst_n(rst_n), .mt_en(mt_en),
    .cfg_st_slots(11'd3), .cfg_st_len(8'd4), .cfg_ms_count(10'd6),
    .cfg_ms_len(8'd2), .cfg_sym_len(8'd2), .cfg_nit_len(8'd3),
    .tx_id(tx_id), .tx_ms(tx_ms), .req(req),
    .seg(seg), .slot(slot), .cycle(cycle), .grant(grant)
  );

  // row: req[36:32] seg[31:30] slot[29:19] cycle[18:13] grant[12:8] dur[7:0]
  localparam logic [36:0] TBL [NROWS] = '{
    {5'b00000, 2'd0, 11'd1, 6'd0, 5'b00000, 8'd4},  // R3
    {5'b00001, 2'd0, 11'd2, 6'd0, 5'b00001, 8'd4},  // R4
    {5'b00000, 2'd0, 11'd3, 6'd0, 5'b00000, 8'd4},  // R3
    {5'b00010, 2'd1, 11'd4, 6'd0, 5'b00010, 8'd6},  // R6
    {5'b00100, 2'd1, 11'd5, 6'd0, 5'b00100, 8'd6},  // R6 exact fit
    {5'b00000, 2'd2, 11'd0, 6'd0, 5'b00000, 8'd2},  // R8
    {5'b11111, 2'd3, 11'd0, 6'd0, 5'b00000, 8'd3},  // R8 req ignored
    {5'b00000, 2'd0, 11'd1, 6'd1, 5'b00000, 8'd4},  // R9
    {5'b01001, 2'd0, 11'd2, 6'd1, 5'b00001, 8'd4},  // R4 tie
    {5'b01000, 2'd0, 11'd3, 6'd1, 5'b00000, 8'd4},  // R4 mismatch
    {5'b00000, 2'd1, 11'd4, 6'd1, 5'b00000, 8'd2},  // R5
    {5'b00100, 2'd1, 11'd5, 6'd1, 5'b00100, 8'd6},  // R6
    {5'b00000, 2'd1, 11'd6, 6'd1, 5'b00000, 8'd2},  // R5
    {5'b10000, 2'd1, 11'd7, 6'd1, 5'b00000, 8'd2},  // R7 too few left
    {5'b00000, 2'd2, 11'd0, 6'd1, 5'b00000, 8'd2},  // R8
    {5'b00000, 2'd3, 11'd0, 6'd1, 5'b00000, 8'd3}   // R2 R8
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1 seg", seg, 0);
    check("R1 slot", slot, 1);
    check("R1 cycle", cycle, 0);
    check("R1 grant", grant, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int r = 0; r < NROWS; r++) begin
      logic [36:0] row;
      logic [12:0] start_id;
      int n;
      bit changed;
      row = TBL[r];
      req = row[36:32];
      #1;
      check($sformatf("R2 row%0d seg", r), seg, row[31:30]);
      check($sformatf("R5 row%0d slot", r), slot, row[29:19]);
      check($sformatf("R9 row%0d cycle", r), cycle, row[18:13]);
      check($sformatf("R4/R11 row%0d grant", r), grant, row[12:8]);
      start_id = {seg, slot};
      n = 1;
      changed = 1'b0;
      while (!changed) begin
        @(negedge clk);
        #1;
        if ({seg, slot} != start_id) changed = 1'b1;
        else begin
          n++;
          if (grant != '0) check($sformatf("R4 row%0d late grant", r), grant, 0);
        end
      end
      check($sformatf("R3/R6/R7 row%0d length", r), n, row[7:0]);
    end

    // R10: hold with enable low, a request pending for a matching later slot
    req = 5'b00001;
    mt_en = 1'b0;
    repeat (5) @(negedge clk);
    #1;
    check("R10 seg", seg, 0);
    check("R10 slot", slot, 1);
    check("R10 cycle", cycle, 2);
    check("R10 grant", grant, 0);
    mt_en = 1'b1;
    req = '0;

    // R9: wrap from 63 to 0
    while (cycle != 6'd63) @(negedge clk);
    while (cycle == 6'd63) @(negedge clk);
    #1;
    check("R9 wrap cycle", cycle, 0);
    check("R9 wrap seg", seg, 0);
    check("R9 wrap slot", slot, 1);

    finish_run();
  end
endmodule